// File: doc/BRIEF.md
# Inter-Processor Doorbell Mailbox

This block lets two processors, called side A and side B, interrupt each other through three separate doorbell links. Link 0 is low priority, link 1 is high priority and link 2 is reserved for secure software. Each link has two 32-bit status words, one for each direction. A processor rings a doorbell by setting a bit in its transmit word. That word is the receive word of the other side, and the OR of its bits drives the other side's interrupt line for that link. The receiver handles each bit as its own event and clears it when done. The sender polls its transmit status and sees the bit drop to zero once the receiver has cleared it.

Each side has its own APB-style completer port with a 12-bit byte address. The port finishes every transfer in one access cycle. The receive register group of link k is at the link's base offset, and the transmit group of the same link is 0x100 above it. Inside a group, offset 0x00 reads the status, a write to offset 0x08 sets bits and a write to offset 0x10 clears bits. Only secure accesses may reach the secure link. A non-secure access to it gets an error response and changes nothing.

Top module: `ipc_doorbell_mbox`

## Requirements
- R1: After reset every status word reads 0x0000_0000 on both ports and all six interrupt outputs are low.
- R2: A write to offset 0x08 of a group ORs the written data into that group's status word. Bits written as 0 keep their value.
- R3: A write to offset 0x10 of a group clears the status bits written as 1. Bits written as 0 keep their value.
- R4: The transmit word of a link on one side (group base + 0x100) is the same storage as the receive word of that link on the other side (group base). Both read the same value, and either side's set or clear changes it.
- R5: Interrupt output bit k of a side is high exactly when that side's receive word for link k is nonzero. It is registered and changes at the same clock edge as the word.
- R6: Link 0 groups start at 0x000, link 1 groups at 0x020 and link 2 groups at 0x200. Interrupt output bit index equals the link index.
- R7: When set and clear requests reach the same status word in one cycle, from either port, a bit named in both ends up set.
- R8: A non-secure access (pprot_ns = 1) to a link 2 group (0x200-0x21F or 0x300-0x31F) writes nothing, reads zero and raises pslverr. A secure access (pprot_ns = 0) to the same groups works normally with pslverr low.
- R9: Accesses to any other offset read zero, change no status word and leave pslverr low.
- R10: pready is high on both ports at all times.
- R11: A write to one link's group changes no status word of any other link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_psel | input | 1 | Side A select |
| a_penable | input | 1 | Side A access phase |
| a_pwrite | input | 1 | Side A write (1) or read (0) |
| a_pprot_ns | input | 1 | Side A protection bit 1: 1 = non-secure access |
| a_paddr | input | 12 | Side A byte address |
| a_pwdata | input | 32 | Side A write data |
| a_prdata | output | 32 | Side A read data |
| a_pready | output | 1 | Side A ready, always 1 |
| a_pslverr | output | 1 | Side A error response |
| a_irq | output | 3 | Side A doorbell interrupts, one per link |
| b_psel | input | 1 | Side B select |
| b_penable | input | 1 | Side B access phase |
| b_pwrite | input | 1 | Side B write (1) or read (0) |
| b_pprot_ns | input | 1 | Side B protection bit 1: 1 = non-secure access |
| b_paddr | input | 12 | Side B byte address |
| b_pwdata | input | 32 | Side B write data |
| b_prdata | output | 32 | Side B read data |
| b_pready | output | 1 | Side B ready, always 1 |
| b_pslverr | output | 1 | Side B error response |
| b_irq | output | 3 | Side B doorbell interrupts, one per link |

## Verification
Read data and pslverr depend combinationally on the current access phase. The bench therefore checks them in the same cycle the access phase is driven, at the falling edge just before the closing rising edge. A write takes effect at the rising edge that ends its access phase. The new status and the interrupt lines are due one cycle after the access phase, so the bench updates its reference model just after that edge and compares both interrupt vectors against the model at every falling edge. Status read back in any later access then has to match the model.

// File: rtl/ipc_db_pkg.sv
package ipc_db_pkg;
  localparam int NLINK     = 3;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int SEC_LINK  = 2;
  localparam int GRP_LSB   = 5;
  localparam int TX_OFFSET = 'h100;

  localparam logic [GRP_LSB-1:0] OFF_STAT = 5'h00;
  localparam logic [GRP_LSB-1:0] OFF_SET  = 5'h08;
  localparam logic [GRP_LSB-1:0] OFF_CLR  = 5'h10;

  // receive group base of each link on either side
  function automatic logic [AW-1:0] link_base(input int k);
    case (k)
      0:       link_base = 12'h000;
      1:       link_base = 12'h020;
      default: link_base = 12'h200;
    endcase
  endfunction
endpackage

// File: rtl/ipc_db_word.sv
module ipc_db_word #(
  parameter int DW = ipc_db_pkg::DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_m,
  input  logic [DW-1:0] clr_m,
  output logic [DW-1:0] word,
  output logic          irq
);
  logic [DW-1:0] word_nxt;
  logic          irq_nxt;
  logic          upd_en;

  // next state: clear first, then set, so a set wins
  always_comb begin
    upd_en   = (|set_m) || (|clr_m);
    word_nxt = (word & ~clr_m) | set_m;
    irq_nxt  = |word_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
      irq  <= 1'b0;
    end else if (upd_en) begin
      word <= word_nxt;
      irq  <= irq_nxt;
    end
  end
endmodule

// File: rtl/ipc_db_port.sv
module ipc_db_port #(
  parameter int DW    = ipc_db_pkg::DW,
  parameter int AW    = ipc_db_pkg::AW,
  parameter int NLINK = ipc_db_pkg::NLINK
) (
  input  logic                      psel,
  input  logic                      penable,
  input  logic                      pwrite,
  input  logic                      prot_ns,
  input  logic [AW-1:0]             paddr,
  input  logic [DW-1:0]             pwdata,
  input  logic [NLINK-1:0][DW-1:0]  rx_word,
  input  logic [NLINK-1:0][DW-1:0]  tx_word,
  output logic [DW-1:0]             prdata,
  output logic                      pslverr,
  output logic [NLINK-1:0][DW-1:0]  rx_set,
  output logic [NLINK-1:0][DW-1:0]  rx_clr,
  output logic [NLINK-1:0][DW-1:0]  tx_set,
  output logic [NLINK-1:0][DW-1:0]  tx_clr
);
  import ipc_db_pkg::*;
  localparam int GW = AW - GRP_LSB;

  logic                access;
  logic [GRP_LSB-1:0]  off;
  logic [GW-1:0]       grp;
  logic [NLINK-1:0]    hit_rx, hit_tx, deny, ok_rx, ok_tx;
  logic                wr_set, wr_clr, rd_stat;

  assign access  = psel && penable;
  assign off     = paddr[GRP_LSB-1:0];
  assign grp     = paddr[AW-1:GRP_LSB];
  assign wr_set  = pwrite && (off == OFF_SET);
  assign wr_clr  = pwrite && (off == OFF_CLR);
  assign rd_stat = !pwrite && (off == OFF_STAT);

  for (genvar k = 0; k < NLINK; k++) begin : g_link
    localparam logic [AW-1:0] RXB    = link_base(k);
    localparam logic [AW-1:0] TXB    = RXB + AW'(TX_OFFSET);
    localparam bit            IS_SEC = (k == SEC_LINK);

    assign hit_rx[k] = (grp == RXB[AW-1:GRP_LSB]);
    assign hit_tx[k] = (grp == TXB[AW-1:GRP_LSB]);
    assign deny[k]   = IS_SEC && prot_ns;
    assign ok_rx[k]  = access && hit_rx[k] && !deny[k];
    assign ok_tx[k]  = access && hit_tx[k] && !deny[k];

    assign rx_set[k] = (ok_rx[k] && wr_set) ? pwdata : '0;
    assign rx_clr[k] = (ok_rx[k] && wr_clr) ? pwdata : '0;
    assign tx_set[k] = (ok_tx[k] && wr_set) ? pwdata : '0;
    assign tx_clr[k] = (ok_tx[k] && wr_clr) ? pwdata : '0;
  end

  always_comb begin
    prdata = '0;
    for (int k = 0; k < NLINK; k++) begin
      if (ok_rx[k] && rd_stat) prdata = prdata | rx_word[k];
      if (ok_tx[k] && rd_stat) prdata = prdata | tx_word[k];
    end
    pslverr = access && (|((hit_rx | hit_tx) & deny));
  end
endmodule

// File: rtl/ipc_doorbell_mbox.sv
module ipc_doorbell_mbox #(
  parameter int DW    = ipc_db_pkg::DW,
  parameter int AW    = ipc_db_pkg::AW,
  parameter int NLINK = ipc_db_pkg::NLINK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_psel,
  input  logic             a_penable,
  input  logic             a_pwrite,
  input  logic             a_pprot_ns,
  input  logic [AW-1:0]    a_paddr,
  input  logic [DW-1:0]    a_pwdata,
  output logic [DW-1:0]    a_prdata,
  output logic             a_pready,
  output logic             a_pslverr,
  output logic [NLINK-1:0] a_irq,
  input  logic             b_psel,
  input  logic             b_penable,
  input  logic             b_pwrite,
  input  logic             b_pprot_ns,
  input  logic [AW-1:0]    b_paddr,
  input  logic [DW-1:0]    b_pwdata,
  output logic [DW-1:0]    b_prdata,
  output logic             b_pready,
  output logic             b_pslverr,
  output logic [NLINK-1:0] b_irq
);
  // reset: asserted asynchronously, released after two clocks
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  // w_ab: A transmits, B receives; w_ba: B transmits, A receives
  logic [NLINK-1:0][DW-1:0] w_ab, w_ba;
  logic [NLINK-1:0][DW-1:0] a_rx_set, a_rx_clr, a_tx_set, a_tx_clr;
  logic [NLINK-1:0][DW-1:0] b_rx_set, b_rx_clr, b_tx_set, b_tx_clr;

  assign a_pready = 1'b1;
  assign b_pready = 1'b1;

  ipc_db_port #(.DW(DW), .AW(AW), .NLINK(NLINK)) u_port_a (
    .psel(a_psel), .penable(a_penable), .pwrite(a_pwrite), .prot_ns(a_pprot_ns),
    .paddr(a_paddr), .pwdata(a_pwdata), .rx_word(w_ba), .tx_word(w_ab),
    .prdata(a_prdata), .pslverr(a_pslverr),
    .rx_set(a_rx_set), .rx_clr(a_rx_clr), .tx_set(a_tx_set), .tx_clr(a_tx_clr)
  );

  ipc_db_port #(.DW(DW), .AW(AW), .NLINK(NLINK)) u_port_b (
    .psel(b_psel), .penable(b_penable), .pwrite(b_pwrite), .prot_ns(b_pprot_ns),
    .paddr(b_paddr), .pwdata(b_pwdata), .rx_word(w_ab), .tx_word(w_ba),
    .prdata(b_prdata), .pslverr(b_pslverr),
    .rx_set(b_rx_set), .rx_clr(b_rx_clr), .tx_set(b_tx_set), .tx_clr(b_tx_clr)
  );

  for (genvar k = 0; k < NLINK; k++) begin : g_words
    ipc_db_word #(.DW(DW)) u_ab (
      .clk(clk), .rst_n(rst_q_n),
      .set_m(a_tx_set[k] | b_rx_set[k]),
      .clr_m(a_tx_clr[k] | b_rx_clr[k]),
      .word(w_ab[k]), .irq(b_irq[k])
    );
    ipc_db_word #(.DW(DW)) u_ba (
      .clk(clk), .rst_n(rst_q_n),
      .set_m(b_tx_set[k] | a_rx_set[k]),
      .clr_m(b_tx_clr[k] | a_rx_clr[k]),
      .word(w_ba[k]), .irq(a_irq[k])
    );
  end
endmodule

// File: rtl/ipc_db_checker.sv
module ipc_db_checker (
  input logic            clk,
  input logic            rst_n,
  input logic            a_psel,
  input logic            a_penable,
  input logic            a_pwrite,
  input logic            a_pprot_ns,
  input logic [11:0]     a_paddr,
  input logic [31:0]     a_pwdata,
  input logic            a_pslverr,
  input logic [2:0]      a_irq,
  input logic            b_psel,
  input logic            b_penable,
  input logic [2:0]      b_irq,
  input logic [2:0][31:0] w_ab,
  input logic [2:0][31:0] w_ba
);
  logic [2:0] or_ab, or_ba;
  logic       a_acc, b_acc, a_secgrp;

  always_comb begin
    for (int k = 0; k < 3; k++) begin
      or_ab[k] = |w_ab[k];
      or_ba[k] = |w_ba[k];
    end
    a_acc    = a_psel && a_penable;
    b_acc    = b_psel && b_penable;
    a_secgrp = (a_paddr[11:5] == 7'h10) || (a_paddr[11:5] == 7'h18);
  end

  AST_IRQ_A_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    a_irq == or_ba); // R5
  AST_IRQ_B_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    b_irq == or_ab); // R5
  AST_SEC_NS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && a_pprot_ns && a_secgrp) |-> a_pslverr); // R8
  AST_SEC_NS_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && a_pwrite && a_pprot_ns && a_secgrp && !b_acc)
      |=> ($stable(w_ab[2]) && $stable(w_ba[2]))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && a_pwrite && a_paddr == 12'h108)
      |=> ((w_ab[0] & $past(a_pwdata)) == $past(a_pwdata))); // R7
  AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && a_pwrite && a_paddr == 12'h110 && !b_acc)
      |=> ((w_ab[0] & $past(a_pwdata)) == 32'h0)); // R3
  AST_UNDEC_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
    (a_acc && !a_secgrp) |-> !a_pslverr); // R9
endmodule

bind ipc_doorbell_mbox ipc_db_checker u_chk (
  .clk(clk), .rst_n(rst_q_n),
  .a_psel(a_psel), .a_penable(a_penable), .a_pwrite(a_pwrite),
  .a_pprot_ns(a_pprot_ns), .a_paddr(a_paddr), .a_pwdata(a_pwdata),
  .a_pslverr(a_pslverr), .a_irq(a_irq),
  .b_psel(b_psel), .b_penable(b_penable), .b_irq(b_irq),
  .w_ab(w_ab), .w_ba(w_ba)
);

// File: tb/tb_ipc_doorbell_mbox.sv
module tb_ipc_doorbell_mbox;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        a_psel, a_penable, a_pwrite, a_pprot_ns;
  logic [11:0] a_paddr;
  logic [31:0] a_pwdata, a_prdata;
  logic        a_pready, a_pslverr;
  logic [2:0]  a_irq;
  logic        b_psel, b_penable, b_pwrite, b_pprot_ns;
  logic [11:0] b_paddr;
  logic [31:0] b_pwdata, b_prdata;
  logic        b_pready, b_pslverr;
  logic [2:0]  b_irq;

  ipc_doorbell_mbox dut (.*);

  int n_chk = 0, n_bad = 0;
  bit live = 0;
  bit done = 0;

  // reference model: m_ab = A transmit / B receive, m_ba = B transmit / A receive
  logic [31:0] m_ab [3];
  logic [31:0] m_ba [3];
  logic [31:0] s_ab [3], c_ab [3], s_ba [3], c_ba [3];
  int          bases [3] = '{'h000, 'h020, 'h200};

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // locate the word an access addresses: returns -1 if undecoded
  // to_ab = 1 when the word is m_ab
  function automatic int locate(input bit side_b, input logic [11:0] addr,
                                output bit to_ab, output bit sec);
    int lk = -1;
    bit tx = 0;
    for (int k = 0; k < 3; k++) begin
      if (addr[11:5] == 7'(bases[k] >> 5))         begin lk = k; tx = 0; end
      if (addr[11:5] == 7'((bases[k] + 'h100) >> 5)) begin lk = k; tx = 1; end
    end
    to_ab = (side_b != tx);
    sec   = (lk == 2);
    return lk;
  endfunction

  function automatic logic [31:0] exp_read(input bit side_b, input bit ns,
                                           input logic [11:0] addr, output bit err);
    bit to_ab, sec;
    int lk = locate(side_b, addr, to_ab, sec);
    err = (lk >= 0) && sec && ns;
    if (lk < 0 || err || addr[4:0] != 5'h00) return 32'h0;
    return to_ab ? m_ab[lk] : m_ba[lk];
  endfunction

  task automatic add_write(input bit side_b, input bit ns,
                           input logic [11:0] addr, input logic [31:0] d);
    bit to_ab, sec;
    int lk = locate(side_b, addr, to_ab, sec);
    if (lk < 0 || (sec && ns)) return;
    if (addr[4:0] == 5'h08) begin
      if (to_ab) s_ab[lk] |= d; else s_ba[lk] |= d;
    end else if (addr[4:0] == 5'h10) begin
      if (to_ab) c_ab[lk] |= d; else c_ba[lk] |= d;
    end
  endtask

  // one access on either or both ports, same cycle
  task automatic xfer(input bit ae, input bit aw, input bit ans, input logic [11:0] aa,
                      input logic [31:0] ad,
                      input bit be, input bit bw, input bit bns, input logic [11:0] ba,
                      input logic [31:0] bd, input string tag);
    bit ea, eb;
    logic [31:0] ra, rb;
    @(negedge clk);
    a_psel = ae; a_penable = 0; a_pwrite = aw; a_pprot_ns = ans; a_paddr = aa; a_pwdata = ad;
    b_psel = be; b_penable = 0; b_pwrite = bw; b_pprot_ns = bns; b_paddr = ba; b_pwdata = bd;
    @(negedge clk);
    a_penable = ae; b_penable = be;
    #1;
    ra = exp_read(1'b0, ans, aa, ea);
    rb = exp_read(1'b1, bns, ba, eb);
    if (ae) begin
      if (!aw) check(tag, "a_prdata", a_prdata, ra);
      check(tag, "a_pslverr", {31'h0, a_pslverr}, {31'h0, ea});
      check("R10", "a_pready", {31'h0, a_pready}, 32'h1);
    end
    if (be) begin
      if (!bw) check(tag, "b_prdata", b_prdata, rb);
      check(tag, "b_pslverr", {31'h0, b_pslverr}, {31'h0, eb});
      check("R10", "b_pready", {31'h0, b_pready}, 32'h1);
    end
    for (int k = 0; k < 3; k++) begin
      s_ab[k] = 0; c_ab[k] = 0; s_ba[k] = 0; c_ba[k] = 0;
    end
    if (ae && aw) add_write(1'b0, ans, aa, ad);
    if (be && bw) add_write(1'b1, bns, ba, bd);
    @(posedge clk);
    #1;
    for (int k = 0; k < 3; k++) begin
      m_ab[k] = (m_ab[k] & ~c_ab[k]) | s_ab[k];
      m_ba[k] = (m_ba[k] & ~c_ba[k]) | s_ba[k];
    end
    a_psel = 0; a_penable = 0; b_psel = 0; b_penable = 0;
  endtask

  task automatic wa(input logic [11:0] ad, input logic [31:0] d, input bit ns, input string t);
    xfer(1, 1, ns, ad, d, 0, 0, 0, 12'h0, 32'h0, t);
  endtask
  task automatic wb(input logic [11:0] ad, input logic [31:0] d, input bit ns, input string t);
    xfer(0, 0, 0, 12'h0, 32'h0, 1, 1, ns, ad, d, t);
  endtask
  task automatic ra(input logic [11:0] ad, input bit ns, input string t);
    xfer(1, 0, ns, ad, 32'h0, 0, 0, 0, 12'h0, 32'h0, t);
  endtask
  task automatic rb(input logic [11:0] ad, input bit ns, input string t);
    xfer(0, 0, 0, 12'h0, 32'h0, 1, 0, ns, ad, 32'h0, t);
  endtask

  task automatic read_all(input string t);
    for (int k = 0; k < 3; k++) begin
      ra(12'(bases[k]), 0, t);
      ra(12'(bases[k] + 'h100), 0, t);
      rb(12'(bases[k]), 0, t);
      rb(12'(bases[k] + 'h100), 0, t);
    end
  endtask

  // per-clock interrupt comparison (R5)
  always @(negedge clk) begin
    if (live) begin
      logic [2:0] ea, eb;
      for (int k = 0; k < 3; k++) begin
        ea[k] = |m_ba[k];
        eb[k] = |m_ab[k];
      end
      check("R5", "a_irq", {29'h0, a_irq}, {29'h0, ea});
      check("R5", "b_irq", {29'h0, b_irq}, {29'h0, eb});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) begin m_ab[k] = 0; m_ba[k] = 0; end
    rst_n = 0;
    a_psel = 0; a_penable = 0; a_pwrite = 0; a_pprot_ns = 0; a_paddr = 0; a_pwdata = 0;
    b_psel = 0; b_penable = 0; b_pwrite = 0; b_pprot_ns = 0; b_paddr = 0; b_pwdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    live = 1;

    // R1: reset state
    check("R1", "a_irq reset", {29'h0, a_irq}, 32'h0);
    check("R1", "b_irq reset", {29'h0, b_irq}, 32'h0);
    read_all("R1");

    // R2: set ORs bits in, zeros keep
    wa(12'h108, 32'h0000_00F0, 0, "R2");
    wa(12'h108, 32'h0000_0001, 0, "R2");
    ra(12'h100, 0, "R2");
    // R4: same storage seen from the other side
    rb(12'h000, 0, "R4");
    wb(12'h128, 32'h8000_0000, 0, "R4");
    ra(12'h020, 0, "R4");
    rb(12'h120, 0, "R4");

    // R3: receiver clears, sender observes
    wb(12'h010, 32'h0000_0030, 0, "R3");
    ra(12'h100, 0, "R3");
    wa(12'h030, 32'h8000_0000, 0, "R3");
    rb(12'h120, 0, "R3");

    // R7: set from A and clear from B on same word, same cycle
    xfer(1, 1, 0, 12'h108, 32'h0000_FF00, 1, 1, 0, 12'h010, 32'h0000_0FC1, "R7");
    rb(12'h000, 0, "R7");
    // R7: set and clear from both ports on link 1 word of B->A
    xfer(1, 1, 0, 12'h028, 32'h00FF_0000, 1, 1, 0, 12'h130, 32'h0F0F_0000, "R7");
    ra(12'h020, 0, "R7");

    // R6 / R11: each link separately, others unchanged
    wa(12'h108, 32'h0000_0000, 0, "R11");
    wa(12'h128, 32'h1234_0000, 0, "R6");
    read_all("R11");
    wa(12'h308, 32'hA5A5_0000, 0, "R6");
    rb(12'h200, 0, "R6");
    wb(12'h308, 32'h0000_0002, 0, "R6");
    read_all("R6");

    // R8: non-secure accesses to link 2 groups
    wa(12'h308, 32'h0000_0FFF, 1, "R8");
    wa(12'h310, 32'hFFFF_FFFF, 1, "R8");
    ra(12'h300, 1, "R8");
    rb(12'h200, 1, "R8");
    wb(12'h210, 32'h0000_0002, 1, "R8");
    ra(12'h200, 0, "R8");
    rb(12'h200, 0, "R8");
    wb(12'h210, 32'hFFFF_0000, 0, "R8");
    rb(12'h200, 0, "R8");
    // R8: non-secure access to non-secure links is fine
    ra(12'h020, 1, "R8");

    // R9: undecoded offsets
    wa(12'h104, 32'hFFFF_FFFF, 0, "R9");
    wa(12'h00C, 32'hFFFF_FFFF, 0, "R9");
    wb(12'h018, 32'hFFFF_FFFF, 0, "R9");
    wb(12'h400, 32'hFFFF_FFFF, 0, "R9");
    wa(12'h228, 32'hFFFF_FFFF, 1, "R9");
    ra(12'h108, 0, "R9");
    rb(12'h004, 0, "R9");
    ra(12'h040, 0, "R9");
    read_all("R9");

    // clear everything, interrupts must drop (R3, R5)
    for (int k = 0; k < 3; k++) begin
      wa(12'(bases[k] + 'h10), 32'hFFFF_FFFF, 0, "R3");
      wb(12'(bases[k] + 'h10), 32'hFFFF_FFFF, 0, "R3");
    end
    read_all("R3");
    check("R5", "a_irq idle", {29'h0, a_irq}, 32'h0);
    check("R5", "b_irq idle", {29'h0, b_irq}, 32'h0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule